// File: doc/BRIEF.md
# Redundant Switching State Selector for Cascaded H-Bridge Inverters

This block turns one vertex of the space-vector lattice into three signed phase levels for a three-phase inverter built from cascaded H-bridges. Each phase has `CELLS` bridges, so each phase can produce `2*CELLS+1` levels, from `-CELLS` to `+CELLS`. The vertex is given as an integer pair (m, n) in the first sector's oblique frame, together with the sector number. Most vertices can be produced by several equivalent phase-level triples. The block picks one of them from closed-form expressions, and the parity of m and n selects which expression applies. It then rotates the triple and negates it to suit the requested sector. It also reports how many redundant triples share that vertex.

Input and output are streams with valid/ready handshakes and one register slice between them. An input beat is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An output beat stays on the outputs, unchanged, until `out_ready` is sampled high. An input that cannot be realised produces no output beat. Instead it raises a one-cycle status pulse, and the output data keep their last values. Such an input is a coordinate with m+n above `2*CELLS`, or a sector code outside 1..6.

Top module: `redund_state_sel`

## Requirements
- R1: When m+n is even, the sector-1 triple is (A,B,C) = ((m+n)/2, (n-m)/2, -(m+n)/2). For example, (1,1) gives (1,0,-1).
- R2: When m is odd and n is even, the sector-1 triple is ((m+n+1)/2, (n-m+1)/2, -(m+n-1)/2).
- R3: When m is even and n is odd, the sector-1 triple is ((m+n-1)/2, (n-m-1)/2, -(m+n+1)/2).
- R4: Before sector mapping, every emitted triple satisfies A-B = m and B-C = n. Every output level lies in -CELLS..+CELLS and is encoded in two's complement on `LW` bits.
- R5: `redund_cnt` equals 2*CELLS+1-(m+n), as an unsigned binary value, and travels with the levels of the same beat.
- R6: `sector` is a 3-bit binary code. Writing the sector-1 triple as (A,B,C), the outputs for each sector are:
  - 1: (A,B,C)
  - 2: (-B,-C,-A)
  - 3: (C,A,B)
  - 4: (-A,-B,-C)
  - 5: (B,C,A)
  - 6: (-C,-A,-B)
- R7: An accepted input with m+n > 2*CELLS, or with a sector code of 0 or 7, produces no output beat. `err_pulse` is high for exactly the cycle after acceptance, and the level and count outputs keep their previous values.
- R8: A legal input accepted on one edge appears with `out_valid` high after that same edge. While `out_valid` is high and `out_ready` is low, the output beat is held stable and `in_ready` is low.
- R9: After reset, `out_valid` and `err_pulse` are low, all level and count outputs are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| coord_m | input | CW | Vertex coordinate m, unsigned |
| coord_n | input | CW | Vertex coordinate n, unsigned |
| sector | input | 3 | Sector code, 1..6 legal |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| lvl_a | output | LW | Phase A level, two's complement |
| lvl_b | output | LW | Phase B level, two's complement |
| lvl_c | output | LW | Phase C level, two's complement |
| redund_cnt | output | RW | Number of redundant triples at this vertex |
| err_pulse | output | 1 | One-cycle flag for a rejected input |

## Verification
The bench builds the block with CELLS = 3 (a seven-level phase), which gives 3-bit coordinates and 3-bit levels. At this size a full sweep of every coordinate pair in 0..7 against all eight sector codes is only 512 beats. That sweep reaches every parity case, every sector mapping and both illegal-input conditions, including the vertices just past the m+n = 6 boundary. A separate back-pressure sequence stalls the consumer with a second beat waiting. This shows that the held beat does not change and that the waiting beat is taken on the release edge.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [1:0] {
    ROT0 = 2'd0,
    ROT1 = 2'd1,
    ROT2 = 2'd2
  } rot_e;

  typedef struct packed {
    logic legal;
    logic neg;
    rot_e rot;
  } sect_map_t;

  // Sector code to rotation/negation: odd sectors keep sign, even ones invert.
  function automatic sect_map_t decode_sector(input logic [2:0] code);
    sect_map_t r;
    r.legal = 1'b1;
    r.neg   = 1'b0;
    r.rot   = ROT0;
    case (code)
      3'd1: begin r.neg = 1'b0; r.rot = ROT0; end
      3'd2: begin r.neg = 1'b1; r.rot = ROT1; end
      3'd3: begin r.neg = 1'b0; r.rot = ROT2; end
      3'd4: begin r.neg = 1'b1; r.rot = ROT0; end
      3'd5: begin r.neg = 1'b0; r.rot = ROT1; end
      3'd6: begin r.neg = 1'b1; r.rot = ROT2; end
      default: r.legal = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rss_state_pick.sv
module rss_state_pick #(
  parameter int CELLS = 3,
  parameter int CW    = $clog2(2*CELLS+1),
  parameter int LW    = $clog2(CELLS+1)+1,
  parameter int RW    = $clog2(2*CELLS+2)
) (
  input  logic [CW-1:0]        m_i,
  input  logic [CW-1:0]        n_i,
  output logic signed [LW-1:0] a_o,
  output logic signed [LW-1:0] b_o,
  output logic signed [LW-1:0] c_o,
  output logic [RW-1:0]        redund_o,
  output logic                 over_o
);
  localparam int AW = CW + 2;
  localparam logic signed [AW-1:0] ONE    = AW'(1);
  localparam logic signed [AW-1:0] SPAN   = AW'(2*CELLS);
  localparam logic signed [AW-1:0] NLEVEL = AW'(2*CELLS+1);

  logic signed [AW-1:0] ms, ns, sum, diff;
  logic signed [AW-1:0] a_w, b_w, c_w, cnt_w;

  always_comb begin
    ms    = $signed({2'b00, m_i});
    ns    = $signed({2'b00, n_i});
    sum   = ms + ns;
    diff  = ns - ms;
    cnt_w = NLEVEL - sum;
    over_o = (sum > SPAN);
    case ({m_i[0], n_i[0]})
      2'b10: begin            // large state, m odd, n even
        a_w = (sum + ONE) >>> 1;
        b_w = (diff + ONE) >>> 1;
        c_w = -((sum - ONE) >>> 1);
      end
      2'b01: begin            // small state, m even, n odd
        a_w = (sum - ONE) >>> 1;
        b_w = (diff - ONE) >>> 1;
        c_w = -((sum + ONE) >>> 1);
      end
      default: begin          // mean state, m+n even
        a_w = sum >>> 1;
        b_w = diff >>> 1;
        c_w = -(sum >>> 1);
      end
    endcase
    a_o      = a_w[LW-1:0];
    b_o      = b_w[LW-1:0];
    c_o      = c_w[LW-1:0];
    redund_o = cnt_w[RW-1:0];
  end

endmodule

// File: rtl/rss_sector_perm.sv
module rss_sector_perm
  import rss_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic signed [LW-1:0] a_i,
  input  logic signed [LW-1:0] b_i,
  input  logic signed [LW-1:0] c_i,
  input  sect_map_t            map_i,
  output logic [2:0][LW-1:0]   lvl_o
);
  logic [2:0][LW-1:0] base;
  assign base = {c_i, b_i, a_i};

  for (genvar j = 0; j < 3; j++) begin : g_phase
    logic signed [LW-1:0] pick;
    always_comb begin
      case (map_i.rot)
        ROT1:    pick = $signed(base[(j+1)%3]);
        ROT2:    pick = $signed(base[(j+2)%3]);
        default: pick = $signed(base[j]);
      endcase
      lvl_o[j] = map_i.neg ? -pick : pick;
    end
  end

endmodule

// File: rtl/rss_out_slice.sv
module rss_out_slice #(
  parameter int CELLS = 3,
  parameter int LW    = 3,
  parameter int RW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               bad_i,
  input  logic [2:0][LW-1:0] lvl_i,
  input  logic [RW-1:0]      redund_i,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [2:0][LW-1:0] lvl_o,
  output logic [RW-1:0]      redund_o,
  output logic               err_o
);
  logic fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err_o     <= 1'b0;
      lvl_o     <= '0;
      redund_o  <= '0;
    end else begin
      err_o <= fire && bad_i;
      if (fire && !bad_i) begin
        out_valid <= 1'b1;
        lvl_o     <= lvl_i;
        redund_o  <= redund_i;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(lvl_o) && $stable(redund_o)));

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r7_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !out_valid);

  a_r7_err_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($stable(lvl_o) && $stable(redund_o)));

endmodule

// File: rtl/redund_state_sel.sv
module redund_state_sel
  import rss_pkg::*;
#(
  parameter int  CELLS = 3,
  localparam int CW    = $clog2(2*CELLS+1),
  localparam int LW    = $clog2(CELLS+1)+1,
  localparam int RW    = $clog2(2*CELLS+2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] coord_m,
  input  logic [CW-1:0] coord_n,
  input  logic [2:0]    sector,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [LW-1:0] lvl_a,
  output logic [LW-1:0] lvl_b,
  output logic [LW-1:0] lvl_c,
  output logic [RW-1:0] redund_cnt,
  output logic          err_pulse
);
  logic signed [LW-1:0] base_a, base_b, base_c;
  logic [RW-1:0]        redund_w;
  logic                 over_w, bad_w;
  sect_map_t            map_w;
  logic [2:0][LW-1:0]   perm_w, lvl_q;

  rss_state_pick #(.CELLS(CELLS), .CW(CW), .LW(LW), .RW(RW)) pick_i (
    .m_i      (coord_m),
    .n_i      (coord_n),
    .a_o      (base_a),
    .b_o      (base_b),
    .c_o      (base_c),
    .redund_o (redund_w),
    .over_o   (over_w)
  );

  assign map_w = decode_sector(sector);
  assign bad_w = over_w || !map_w.legal;

  rss_sector_perm #(.LW(LW)) perm_i (
    .a_i   (base_a),
    .b_i   (base_b),
    .c_i   (base_c),
    .map_i (map_w),
    .lvl_o (perm_w)
  );

  rss_out_slice #(.CELLS(CELLS), .LW(LW), .RW(RW)) slice_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .bad_i     (bad_w),
    .lvl_i     (perm_w),
    .redund_i  (redund_w),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .lvl_o     (lvl_q),
    .redund_o  (redund_cnt),
    .err_o     (err_pulse)
  );

  assign lvl_a = lvl_q[0];
  assign lvl_b = lvl_q[1];
  assign lvl_c = lvl_q[2];

  // R4: picked triple obeys the phase-difference chain for legal inputs
  a_r4_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad_w) |->
      ((int'(base_a) - int'(base_b) == int'(coord_m)) &&
       (int'(base_b) - int'(base_c) == int'(coord_n))));

  // R4: emitted levels stay inside the phase range
  a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |->
      ($signed(lvl_a) >= -CELLS && $signed(lvl_a) <= CELLS &&
       $signed(lvl_b) >= -CELLS && $signed(lvl_b) <= CELLS &&
       $signed(lvl_c) >= -CELLS && $signed(lvl_c) <= CELLS));

  // R5: count plus coordinate sum spans the level count
  a_r5_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad_w) |->
      (int'(redund_w) + int'(coord_m) + int'(coord_n) == 2*CELLS+1));

  // R7: a rejected accepted beat yields an error pulse next cycle
  a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && bad_w) |=> err_pulse);

endmodule

// File: tb/redund_state_sel_tb_top.sv
module redund_state_sel_tb_top;
  localparam int CELLS = 3;
  localparam int CW = $clog2(2*CELLS+1);
  localparam int LW = $clog2(CELLS+1)+1;
  localparam int RW = $clog2(2*CELLS+2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CW-1:0] coord_m = '0;
  logic [CW-1:0] coord_n = '0;
  logic [2:0] sector = 3'd1;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [LW-1:0] lvl_a, lvl_b, lvl_c;
  logic [RW-1:0] redund_cnt;
  logic err_pulse;

  int n_checks = 0;
  int n_fail = 0;
  int ea = 0, eb = 0, ec = 0, ecnt = 0;

  always #5 clk = ~clk;

  redund_state_sel #(.CELLS(CELLS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .coord_m(coord_m), .coord_n(coord_n), .sector(sector),
    .out_valid(out_valid), .out_ready(out_ready),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
    .redund_cnt(redund_cnt), .err_pulse(err_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected triple computed from the parity formulas and sector table
  task automatic model(input int m, input int n, input int s,
                       output int oa, output int ob, output int oc, output bit bad);
    int a, b, c, sum;
    sum = m + n;
    bad = (sum > 2*CELLS) || (s < 1) || (s > 6);
    if (sum % 2 == 0) begin
      a = sum / 2; b = (n - m) / 2; c = -(sum / 2);
    end else if (m % 2 == 1) begin
      a = (sum + 1) / 2; b = (n - m + 1) / 2; c = -((sum - 1) / 2);
    end else begin
      a = (sum - 1) / 2; b = (n - m - 1) / 2; c = -((sum + 1) / 2);
    end
    case (s)
      2: begin oa = -b; ob = -c; oc = -a; end
      3: begin oa = c;  ob = a;  oc = b;  end
      4: begin oa = -a; ob = -b; oc = -c; end
      5: begin oa = b;  ob = c;  oc = a;  end
      6: begin oa = -c; ob = -a; oc = -b; end
      default: begin oa = a; ob = b; oc = c; end
    endcase
  endtask

  function automatic int sx(input logic [LW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic send(input int m, input int n, input int s);
    int xa, xb, xc;
    bit bad;
    string tag;
    model(m, n, s, xa, xb, xc, bad);
    @(negedge clk);
    coord_m = CW'(m);
    coord_n = CW'(n);
    sector = 3'(s);
    in_valid = 1'b1;
    check("R8 ready before accept", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    if (bad) begin
      check("R7 err pulse", int'(err_pulse), 1);
      check("R7 no beat", int'(out_valid), 0);
      check("R7 lvl_a held", sx(lvl_a), ea);
      check("R7 lvl_b held", sx(lvl_b), eb);
      check("R7 lvl_c held", sx(lvl_c), ec);
      check("R7 count held", int'(redund_cnt), ecnt);
    end else begin
      ea = xa; eb = xb; ec = xc; ecnt = 2*CELLS + 1 - m - n;
      if (s != 1) tag = "R6";
      else if ((m + n) % 2 == 0) tag = "R1/R4";
      else if (m % 2 == 1) tag = "R2/R4";
      else tag = "R3/R4";
      check("R8 valid after one edge", int'(out_valid), 1);
      check("R7 no err", int'(err_pulse), 0);
      check({tag, " lvl_a"}, sx(lvl_a), xa);
      check({tag, " lvl_b"}, sx(lvl_b), xb);
      check({tag, " lvl_c"}, sx(lvl_c), xc);
      check("R5 count", int'(redund_cnt), ecnt);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 out_valid", int'(out_valid), 0);
    check("R9 err", int'(err_pulse), 0);
    check("R9 lvl_a", sx(lvl_a), 0);
    check("R9 lvl_b", sx(lvl_b), 0);
    check("R9 lvl_c", sx(lvl_c), 0);
    check("R9 count", int'(redund_cnt), 0);
    check("R9 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;

    // R1 spot value: (1,1) sector 1 -> (1,0,-1)
    send(1, 1, 1);
    check("R1 example a", sx(lvl_a), 1);
    check("R1 example c", sx(lvl_c), -1);

    // Full sweep
    for (int s = 0; s < 8; s++)
      for (int m = 0; m < 8; m++)
        for (int n = 0; n < 8; n++)
          send(m, n, s);

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(2, 1, 1);
    @(negedge clk);
    coord_m = CW'(1);
    coord_n = CW'(0);
    sector = 3'd5;
    in_valid = 1'b1;
    check("R8 in_ready low under stall", int'(in_ready), 0);
    @(negedge clk);
    @(negedge clk);
    check("R8 held valid", int'(out_valid), 1);
    check("R8 held lvl_a", sx(lvl_a), 1);
    check("R8 held lvl_b", sx(lvl_b), -1);
    check("R8 held lvl_c", sx(lvl_c), -2);
    check("R8 held count", int'(redund_cnt), 4);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // (1,0) large -> (1,0,0); sector 5 gives (0,0,1)
    check("R8 second beat valid", int'(out_valid), 1);
    check("R8/R6 second lvl_a", sx(lvl_a), 0);
    check("R8/R6 second lvl_b", sx(lvl_b), 0);
    check("R8/R6 second lvl_c", sx(lvl_c), 1);
    @(negedge clk);
    check("R8 drained", int'(out_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule